// File: doc/BRIEF.md
# Addressed Discrete I/O Bank with Internal Halt Flag

This block holds sixteen one-bit output latches for a small 4-bit controller core. The core loads a 4-bit select register. It then issues set, clear or test operations, and each one acts only on the latch that the select register names. The latches drive open-drain style pins: a latch value of 1 releases the pin and a value of 0 pulls it low. A test returns the AND of the selected latch and the level seen on its pin. Software must therefore release a latch before it can read the true pin level.

The two top bits change their role according to a build-time option:

- **Pins:** both top bits are plain pins.
- **Registers:** both top bits are internal one-bit registers that are cut off from their pins.
- **Registers with halt:** as for Registers, and the top bit also acts as a run flag.

When the run flag is cleared, the gated core clock stops. A 15-bit prescaler runs from the timer crystal clock and keeps counting during halt. Its overflow is carried safely into the core domain and sets the flag again, which restarts the core clock.

Top module: `dio_halt_bank`

## Requirements
- R1: After reset every latch holds 1, `pin_out` is all ones, `tst_result` is 0 and `core_en` is 1.
- R2: A set (`op_set`) or clear (`op_clr`) changes only the latch selected by the address loaded through `addr_wr`. The address takes effect from the cycle after it is loaded, and the change appears after one core clock edge.
- R3: A test (`op_tst`) registers the selected latch ANDed with its synchronised pin level into `tst_result` on the same edge.
- R4: Under the Pins option, bits 14 and 15 behave like bits 0 to 13. Clearing bit 15 drives `pin_out[15]` low and leaves `core_en` at 1.
- R5: Under either register option, `pin_out[15:14]` stays 1 whatever the register value. A test of bits 14 or 15 returns the register value and ignores `pin_in`.
- R6: Under the Registers-with-halt option, clearing bit 15 drops `core_en` after the clear edge, and `core_clk` then produces no rising edges.
- R7: Under the Registers-with-halt option, a prescaler overflow sets bit 15, so `core_en` returns to 1 without any operation from the core.
- R8: Under the Registers option, a prescaler overflow leaves bit 15 unchanged.
- R9: When an overflow and a clear of bit 15 fall in the same cycle, the set wins.
- R10: Overflows reach the core domain once every 2^PRESC_W timer clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running core clock |
| tclk | input | 1 | Timer crystal clock for the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| addr_wr | input | 1 | Load `addr_in` into the select register |
| addr_in | input | 4 | Latch select value |
| op_set | input | 1 | Set the selected latch to 1 |
| op_clr | input | 1 | Clear the selected latch to 0 |
| op_tst | input | 1 | Test the selected latch against its pin |
| pin_in | input | 16 | Pin levels, asynchronous |
| pin_out | output | 16 | Latch drive, where 1 means released and 0 means pulled low |
| tst_result | output | 1 | Result of the last test |
| core_en | output | 1 | Core clock enable |
| core_clk | output | 1 | Glitch-free gated core clock |

## Verification
On every cycle the checker watches four things:

- Set and clear reach only the selected latch.
- Each overflow pulse lasts one cycle and always leaves the run flag at 1, including when a clear arrives in the same cycle.
- Clearing the run flag drops the enable.
- A test result matches the latch and the synchronised pin.

Only the bench scenarios can show the remaining behaviour:

- The option-dependent role of the top bits.
- The absence of gated clock edges during halt.
- The wake-up that needs no core action.
- The overflow period measured in timer cycles.

// File: rtl/dio_pkg.sv
package dio_pkg;
   typedef enum logic [1:0] {
      HI_PINS = 2'd0,
      HI_REGS = 2'd1,
      HI_HALT = 2'd2
   } hi_opt_e;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dio_presc.sv
module dio_presc #(
   parameter int PRESC_W = 15,
   parameter int SYNC_STAGES = 2
) (
   input  logic tclk,
   input  logic clk,
   input  logic rst_n,
   output logic ovf_pulse
);
   if (PRESC_W < 2) begin : g_bad_w
      $error("dio_presc: PRESC_W must be at least 2");
   end

   localparam logic [PRESC_W-1:0] CNT_MAX = '1;

   logic [PRESC_W-1:0] cnt_q;
   logic               tgl_q;

   // timer domain: free counter, toggle on wrap
   always_ff @(posedge tclk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tgl_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == CNT_MAX) tgl_q <= ~tgl_q;
      end
   end

   // core domain: synchronise toggle, detect edge
   logic tgl_s;
   logic tgl_d;

   dio_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tgl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (tgl_q),
      .q     (tgl_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgl_d <= 1'b0;
      else        tgl_d <= tgl_s;
   end

   assign ovf_pulse = tgl_s ^ tgl_d;
endmodule

// File: rtl/dio_clk_gate.sv
module dio_clk_gate (
   input  logic clk,
   input  logic en,
   output logic gclk
);
   logic en_lat;

   always_latch begin
      if (!clk) en_lat = en;
   end

   assign gclk = clk & en_lat;
endmodule

// File: rtl/dio_halt_bank.sv
module dio_halt_bank #(
   parameter int NUM_BITS    = 16,
   parameter int PRESC_W     = 15,
   parameter int SYNC_STAGES = 2,
   parameter dio_pkg::hi_opt_e HI_OPT = dio_pkg::HI_HALT
) (
   input  logic                          clk,
   input  logic                          tclk,
   input  logic                          rst_n,
   input  logic                          addr_wr,
   input  logic [$clog2(NUM_BITS)-1:0]   addr_in,
   input  logic                          op_set,
   input  logic                          op_clr,
   input  logic                          op_tst,
   input  logic [NUM_BITS-1:0]           pin_in,
   output logic [NUM_BITS-1:0]           pin_out,
   output logic                          tst_result,
   output logic                          core_en,
   output logic                          core_clk
);
   import dio_pkg::*;

   localparam int ADDR_W  = $clog2(NUM_BITS);
   localparam int HALT_IX = NUM_BITS - 1;
   localparam int LOW_TOP = NUM_BITS - 2;
   localparam bit HAS_HALT = (HI_OPT == HI_HALT);

   if (NUM_BITS < 3 || (1 << ADDR_W) != NUM_BITS) begin : g_bad_bits
      $error("dio_halt_bank: NUM_BITS must be a power of two of at least 4");
   end

   logic [ADDR_W-1:0]   addr_q;
   logic [NUM_BITS-1:0] bank_q;
   logic [NUM_BITS-1:0] pin_s;
   logic [NUM_BITS-1:0] in_val;
   logic                ovf_pulse;
   logic                tst_q;

   // select register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (addr_wr) addr_q <= addr_in;
   end

   dio_sync #(.WIDTH(NUM_BITS), .STAGES(SYNC_STAGES), .RST_VAL({NUM_BITS{1'b1}})) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   dio_presc #(.PRESC_W(PRESC_W), .SYNC_STAGES(SYNC_STAGES)) u_presc (
      .tclk      (tclk),
      .clk       (clk),
      .rst_n     (rst_n),
      .ovf_pulse (ovf_pulse)
   );

   // per-bit latches
   for (genvar b = 0; b < NUM_BITS; b++) begin : g_bit
      logic hit;
      logic wake;
      assign hit = (addr_q == ADDR_W'(b));

      if (b == HALT_IX && HAS_HALT) begin : g_wake
         assign wake = ovf_pulse;
      end else begin : g_nowake
         assign wake = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        bank_q[b] <= 1'b1;
         else if (wake || (hit && op_set))  bank_q[b] <= 1'b1;
         else if (hit && op_clr)            bank_q[b] <= 1'b0;
      end

      if (b < LOW_TOP || HI_OPT == HI_PINS) begin : g_pin
         assign pin_out[b] = bank_q[b];
         assign in_val[b]  = pin_s[b];
      end else begin : g_reg
         assign pin_out[b] = 1'b1;
         assign in_val[b]  = 1'b1;
      end
   end

   // test: wired-AND of latch and input
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tst_q <= 1'b0;
      else if (op_tst) tst_q <= bank_q[addr_q] & in_val[addr_q];
   end
   assign tst_result = tst_q;

   if (HAS_HALT) begin : g_halt
      assign core_en = bank_q[HALT_IX];
   end else begin : g_run
      assign core_en = 1'b1;
   end

   dio_clk_gate u_cg (
      .clk  (clk),
      .en   (core_en),
      .gclk (core_clk)
   );
endmodule

// File: rtl/dio_halt_bank_chk.sv
module dio_halt_bank_chk #(
   parameter int NUM_BITS = 16,
   parameter dio_pkg::hi_opt_e HI_OPT = dio_pkg::HI_HALT
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [$clog2(NUM_BITS)-1:0] addr_q,
   input logic [NUM_BITS-1:0]         bank_q,
   input logic [NUM_BITS-1:0]         in_val,
   input logic                        op_set,
   input logic                        op_clr,
   input logic                        op_tst,
   input logic                        ovf_pulse,
   input logic                        tst_result,
   input logic                        core_en
);
   localparam int TOP = NUM_BITS - 1;
   localparam bit HALT = (HI_OPT == dio_pkg::HI_HALT);

   p_set_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
      op_set |=> bank_q[$past(addr_q)]);

   p_one_bit_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_set || op_clr) && !ovf_pulse |=> $countones(bank_q ^ $past(bank_q)) <= 1);

   p_test_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
      op_tst |=> tst_result == ($past(bank_q[addr_q]) & $past(in_val[addr_q])));

   p_clear_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      HALT && op_clr && !op_set && !ovf_pulse && addr_q == TOP |=> !core_en);

   p_ovf_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |=> !ovf_pulse);

   p_ovf_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      HALT && ovf_pulse |=> bank_q[TOP] && core_en);
endmodule

bind dio_halt_bank dio_halt_bank_chk #(.NUM_BITS(NUM_BITS), .HI_OPT(HI_OPT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .addr_q     (addr_q),
   .bank_q     (bank_q),
   .in_val     (in_val),
   .op_set     (op_set),
   .op_clr     (op_clr),
   .op_tst     (op_tst),
   .ovf_pulse  (ovf_pulse),
   .tst_result (tst_result),
   .core_en    (core_en)
);

// File: tb/dio_halt_bank_bench.sv
module dio_halt_bank_bench;
   import dio_pkg::*;

   localparam int  CLK_PERIOD  = 10;
   localparam int  TCLK_PERIOD = 26;
   localparam int  PW          = 4;
   localparam int  OVF_NS      = (1 << PW) * TCLK_PERIOD;

   logic clk = 1'b0;
   logic tclk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_wr = 1'b0;
   logic [3:0] addr_in = '0;
   logic op_set = 1'b0, op_clr = 1'b0, op_tst = 1'b0;
   logic [15:0] pin_in = '1;

   logic [15:0] po_h, po_p, po_r;
   logic tr_h, tr_p, tr_r, en_h, en_p, en_r, gc_h, gc_p, gc_r;

   int checks = 0;
   int fails  = 0;
   int gedges = 0;

   always #(CLK_PERIOD/2)  clk  = ~clk;
   always #(TCLK_PERIOD/2) tclk = ~tclk;
   always @(posedge gc_h) gedges++;

   dio_halt_bank #(.PRESC_W(PW), .HI_OPT(HI_HALT)) u_dio_halt_bank (
      .clk(clk), .tclk(tclk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_in(addr_in),
      .op_set(op_set), .op_clr(op_clr), .op_tst(op_tst), .pin_in(pin_in),
      .pin_out(po_h), .tst_result(tr_h), .core_en(en_h), .core_clk(gc_h));

   dio_halt_bank #(.PRESC_W(PW), .HI_OPT(HI_PINS)) u_dio_halt_bank_pins (
      .clk(clk), .tclk(tclk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_in(addr_in),
      .op_set(op_set), .op_clr(op_clr), .op_tst(op_tst), .pin_in(pin_in),
      .pin_out(po_p), .tst_result(tr_p), .core_en(en_p), .core_clk(gc_p));

   dio_halt_bank #(.PRESC_W(PW), .HI_OPT(HI_REGS)) u_dio_halt_bank_regs (
      .clk(clk), .tclk(tclk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_in(addr_in),
      .op_set(op_set), .op_clr(op_clr), .op_tst(op_tst), .pin_in(pin_in),
      .pin_out(po_r), .tst_result(tr_r), .core_en(en_r), .core_clk(gc_r));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // 0 = set, 1 = clear, 2 = test
   task automatic do_op(input int kind, input logic [3:0] a);
      @(negedge clk); addr_in = a; addr_wr = 1'b1;
      @(negedge clk); addr_wr = 1'b0;
      op_set = (kind == 0); op_clr = (kind == 1); op_tst = (kind == 2);
      @(negedge clk); op_set = 1'b0; op_clr = 1'b0; op_tst = 1'b0;
   endtask

   task automatic wait_wake(output bit ok);
      ok = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (en_h) begin ok = 1'b1; break; end
      end
   endtask

   task automatic t_reset;
      chk("R1 pin_out", po_h, 32'hFFFF);
      chk("R1 tst_result", tr_h, 0);
      chk("R1 core_en", en_h, 1);
   endtask

   task automatic t_select;
      do_op(1, 4'd3);
      chk("R2 clear bit3", po_h, 32'hFFF7);
      do_op(1, 4'd9);
      chk("R2 clear bit9", po_h, 32'hFDF7);
      do_op(0, 4'd3);
      chk("R2 set bit3", po_h, 32'hFDFF);
      do_op(0, 4'd9);
      chk("R2 restore", po_h, 32'hFFFF);
   endtask

   task automatic t_test;
      pin_in[2] = 1'b0; repeat (3) @(negedge clk);
      do_op(2, 4'd2);
      chk("R3 latch1 pin0", tr_h, 0);
      pin_in[2] = 1'b1; repeat (3) @(negedge clk);
      do_op(2, 4'd2);
      chk("R3 latch1 pin1", tr_h, 1);
      do_op(1, 4'd2);
      do_op(2, 4'd2);
      chk("R3 latch0 pin1", tr_h, 0);
      do_op(0, 4'd2);
   endtask

   task automatic t_options;
      do_op(1, 4'd15);
      chk("R4 pins bit15 driven", po_p, 32'h7FFF);
      chk("R4 pins no halt", en_p, 1);
      chk("R5 regs pins released", po_r, 32'hFFFF);
      pin_in[15:14] = 2'b00; repeat (3) @(negedge clk);
      do_op(2, 4'd14);
      chk("R5 regs test ignores pin", tr_r, 1);
      chk("R4 pins test sees pin", tr_p, 0);
      do_op(2, 4'd15);
      chk("R5 regs test reads reg", tr_r, 0);
      pin_in[15:14] = 2'b11;
      do_op(0, 4'd15);
   endtask

   task automatic t_halt_wake;
      bit ok;
      int g0;
      wait_wake(ok);
      do_op(1, 4'd15);
      chk("R6 core_en low", en_h, 0);
      g0 = gedges;
      repeat (5) @(negedge clk);
      if (en_h == 1'b0) chk("R6 no gated edges", gedges - g0, 0);
      wait_wake(ok);
      chk("R7 woke by overflow", ok, 1);
      g0 = gedges;
      repeat (3) @(negedge clk);
      chk("R7 clock resumes", (gedges - g0) > 0, 1);
   endtask

   task automatic t_period;
      bit ok;
      int dt;
      time t1, t2;
      do_op(1, 4'd15);
      wait_wake(ok);
      t1 = $time;
      do_op(1, 4'd15);
      wait_wake(ok);
      t2 = $time;
      dt = int'(t2 - t1);
      chk("R10 period", (dt >= OVF_NS - 2*CLK_PERIOD) && (dt <= OVF_NS + 2*CLK_PERIOD), 1);
   endtask

   task automatic t_regs_no_wake;
      do_op(1, 4'd15);
      repeat (2 * OVF_NS / CLK_PERIOD + 10) @(negedge clk);
      do_op(2, 4'd15);
      chk("R8 regs bit15 stays 0", tr_r, 0);
      do_op(0, 4'd15);
   endtask

   task automatic t_collide;
      int highs = 0;
      @(negedge clk); addr_in = 4'd15; addr_wr = 1'b1;
      @(negedge clk); addr_wr = 1'b0; op_clr = 1'b1;
      for (int i = 0; i < 2 * OVF_NS / CLK_PERIOD + 10; i++) begin
         @(negedge clk);
         if (en_h) highs++;
      end
      op_clr = 1'b0;
      chk("R9 set wins over clear", (highs >= 1) && (highs <= 6), 1);
      do_op(0, 4'd15);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_select();
      t_test();
      t_options();
      t_halt_wake();
      t_period();
      t_regs_no_wake();
      t_collide();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule